// File: doc/BRIEF.md
# Channel Scan Serializer Controller

This block steps through a bank of differential amplifier channels, one per clock, so that a single serial line can carry all of them in turn. A synchronous binary counter, built as a chain of toggle stages, holds the current scan position. A two-level decoder turns that position into a one-hot channel select. The low count bits drive every 4-to-16 sub-decoder, and the upper count bits enable exactly one sub-decoder.

Each select drives the two switches of its channel, one for each leg of the differential pair. Every switch receives a true enable and a complementary enable, in the way a pass gate is driven. For verification the analog path is replaced by a digital multiplexer. It forwards the sample word of the selected channel. An index output reports the channel number, 1 to 64.

Reset parks the scan on the last channel, channel 64. The clocks after reset then visit channels 1 to 63 in ascending order and wrap back to channel 64. With a 64 kHz scan clock, each channel is visited once per millisecond.

Top module: `chscan_top`

## Requirements
- R1: A rising clock edge sampled with `rst` high selects channel 64 for the following cycle: `ch_index` = 64 and `ch_sel[63]` = 1.
- R2: While `rst` stays high across several edges, channel 64 stays selected.
- R3: With `rst` low, each edge moves the selection from channel c to channel c+1 for c in 1..63.
- R4: With `rst` low, the edge after channel 63 selects channel 64, and the edge after channel 64 selects channel 1.
- R5: In every cycle exactly one bit of `ch_sel` is 1, and for channel c it is bit c-1.
- R6: For selected channel c, `sw_en_p` has bits 2(c-1) (positive leg) and 2(c-1)+1 (negative leg) set, and all other bits clear.
- R7: `sw_en_n` is the bitwise inverse of `sw_en_p` in every cycle.
- R8: `serial_out` equals `samples_in[8(c-1) +: 8]` for selected channel c, following changes of `samples_in` within the same cycle.
- R9: `ch_index` reports the selected channel number, from 1 to 64, consistent with `ch_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset; parks the scan on channel 64 |
| samples_in | input | 512 | Per-channel sample words; channel c occupies bits 8(c-1)+7 down to 8(c-1) |
| ch_sel | output | 64 | One-hot channel select; bit c-1 selects channel c |
| sw_en_p | output | 128 | True switch enables, two per channel (positive leg, negative leg) |
| sw_en_n | output | 128 | Complementary switch enables |
| ch_index | output | 7 | Current channel number, 1 to 64 |
| serial_out | output | 8 | Sample word of the selected channel |

## Verification
The assertions assume that `rst` is a clean synchronous level, held for whole cycles and changed only away from the clock edge. They also assume that the counter state after the first reset edge is the only state of interest, so every property is masked while `rst` is high. The bench asserts reset from time zero and changes `rst` and `samples_in` only 1 ns after a rising edge. It also holds reset across several edges, once at start-up and once in the middle of a scan. As a result, every property starts from a parked channel-64 state.

// File: rtl/chscan_pkg.sv
package chscan_pkg;
  localparam int unsigned DEF_NUM_CH   = 64;
  localparam int unsigned DEF_SUB_W    = 4;
  localparam int unsigned DEF_SAMPLE_W = 8;

  // Count value 0 stands for the last channel; any other count k is channel k.
  function automatic int unsigned chan_of(input int unsigned count,
                                          input int unsigned num_ch);
    return (count == 0) ? num_ch : count;
  endfunction

  // Bit position in the one-hot select vector for a channel number 1..num_ch.
  function automatic int unsigned sel_bit_of(input int unsigned chan);
    return chan - 1;
  endfunction
endpackage

// File: rtl/chscan_counter.sv
module chscan_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_wrap
);
  // carry[i] high means every bit below i is 1, so stage i toggles.
  logic [CNT_W:0] carry;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    assign carry[i+1] = carry[i] & cnt[i];
    always_ff @(posedge clk) begin
      if (rst) cnt[i] <= 1'b0;
      else     cnt[i] <= cnt[i] ^ carry[i];
    end
  end

  assign cnt_wrap = carry[CNT_W];
endmodule

// File: rtl/chscan_subdec.sv
module chscan_subdec #(
  parameter int unsigned SUB_W = 4,
  localparam int unsigned OUT_N = 1 << SUB_W
) (
  input  logic [SUB_W-1:0] addr,
  input  logic             en,
  output logic [OUT_N-1:0] y
);
  always_comb begin
    y = '0;
    if (en) y[addr] = 1'b1;
  end
endmodule

// File: rtl/chscan_decoder.sv
module chscan_decoder #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned SUB_W = 4,
  localparam int unsigned HI_W   = CNT_W - SUB_W,
  localparam int unsigned NUM_SUB = 1 << HI_W,
  localparam int unsigned SUB_N  = 1 << SUB_W,
  localparam int unsigned OUT_N  = 1 << CNT_W
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [OUT_N-1:0] dec
);
  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] lo;
  assign hi = cnt[CNT_W-1:SUB_W];
  assign lo = cnt[SUB_W-1:0];

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    logic sub_en;
    assign sub_en = (hi == HI_W'(g));
    chscan_subdec #(.SUB_W(SUB_W)) u_sub (
      .addr(lo),
      .en  (sub_en),
      .y   (dec[g*SUB_N +: SUB_N])
    );
  end
endmodule

// File: rtl/chscan_switches.sv
module chscan_switches #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic [NUM_CH-1:0]   sel,
  output logic [2*NUM_CH-1:0] en_p,
  output logic [2*NUM_CH-1:0] en_n
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_pair
    assign en_p[2*k]   = sel[k];
    assign en_p[2*k+1] = sel[k];
    assign en_n[2*k]   = ~sel[k];
    assign en_n[2*k+1] = ~sel[k];
  end
endmodule

// File: rtl/chscan_top.sv
module chscan_top #(
  parameter int unsigned NUM_CH   = chscan_pkg::DEF_NUM_CH,
  parameter int unsigned SUB_W    = chscan_pkg::DEF_SUB_W,
  parameter int unsigned SAMPLE_W = chscan_pkg::DEF_SAMPLE_W,
  localparam int unsigned CNT_W   = $clog2(NUM_CH),
  localparam int unsigned IDX_W   = CNT_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_in,
  output logic [NUM_CH-1:0]          ch_sel,
  output logic [2*NUM_CH-1:0]        sw_en_p,
  output logic [2*NUM_CH-1:0]        sw_en_n,
  output logic [IDX_W-1:0]           ch_index,
  output logic [SAMPLE_W-1:0]        serial_out
);
  logic [CNT_W-1:0]  cnt;
  logic              cnt_wrap;   // named event: counter at all-ones
  logic [NUM_CH-1:0] dec;        // one-hot in count order

  chscan_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cnt_wrap(cnt_wrap)
  );

  chscan_decoder #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_dec (
    .cnt(cnt),
    .dec(dec)
  );

  // Count 0 is the last channel; count k is channel k at select bit k-1.
  assign ch_sel = {dec[0], dec[NUM_CH-1:1]};

  chscan_switches #(.NUM_CH(NUM_CH)) u_sw (
    .sel (ch_sel),
    .en_p(sw_en_p),
    .en_n(sw_en_n)
  );

  assign ch_index = IDX_W'(chscan_pkg::chan_of(32'(cnt), NUM_CH));

  // Behavioural stand-in for the analog switch network.
  always_comb begin
    serial_out = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_sel[k]) serial_out = serial_out | samples_in[k*SAMPLE_W +: SAMPLE_W];
    end
  end
endmodule

// File: rtl/chscan_chk.sv
module chscan_chk #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned IDX_W = $clog2(NUM_CH) + 1
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_CH-1:0]   ch_sel,
  input logic [2*NUM_CH-1:0] sw_en_p,
  input logic [2*NUM_CH-1:0] sw_en_n,
  input logic [IDX_W-1:0]    ch_index,
  input logic                cnt_wrap
);
  assert_onehot_sel_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(ch_sel) == 1);

  assert_two_legs_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(sw_en_p) == 2);

  assert_complement_R7: assert property (@(posedge clk) disable iff (rst)
    ((sw_en_p & sw_en_n) == '0) && ((sw_en_p | sw_en_n) == '1));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
    (ch_index < IDX_W'(NUM_CH - 1)) |=> (ch_index == $past(ch_index) + 1'b1));

  assert_wrap_last_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_wrap |=> (ch_index == IDX_W'(NUM_CH)));

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_index == IDX_W'(NUM_CH)) |=> (ch_index == IDX_W'(1)));

  assert_index_sel_R9: assert property (@(posedge clk) disable iff (rst)
    ch_sel[ch_index - 1'b1] == 1'b1);

  assert_wrap_at_63_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_wrap == (ch_index == IDX_W'(NUM_CH - 1)));
endmodule

bind chscan_top chscan_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ch_sel  (ch_sel),
  .sw_en_p (sw_en_p),
  .sw_en_n (sw_en_n),
  .ch_index(ch_index),
  .cnt_wrap(cnt_wrap)
);

// File: tb/sim_chscan_top.sv
`timescale 1ns/1ps
module sim_chscan_top;
  localparam int N  = 64;
  localparam int SW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*SW-1:0] samples_in;
  logic [N-1:0]    ch_sel;
  logic [2*N-1:0]  sw_en_p, sw_en_n;
  logic [6:0]      ch_index;
  logic [SW-1:0]   serial_out;

  int n_checks = 0;
  int n_fail   = 0;
  int seed     = 0;
  int exp_ch   = 64;
  bit model_ok = 1'b0;
  bit rst_seen = 1'b0;   // rst sampled high at the latest edge
  bit finished = 1'b0;
  int visit_q[$];        // order of channels visited since last reset

  always #2.5 clk = ~clk;

  chscan_top u0 (
    .clk(clk), .rst(rst), .samples_in(samples_in), .ch_sel(ch_sel),
    .sw_en_p(sw_en_p), .sw_en_n(sw_en_n), .ch_index(ch_index), .serial_out(serial_out)
  );

  function automatic logic [SW-1:0] word_of(int ch, int s);
    return SW'((ch * 37 + s * 11 + 5) % 256);
  endfunction

  function automatic logic [N*SW-1:0] fill(int s);
    logic [N*SW-1:0] v;
    for (int c = 1; c <= N; c++) v[(c-1)*SW +: SW] = word_of(c, s);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: the channel number advances modulo the bank size.
  always @(posedge clk) begin
    rst_seen <= rst;
    if (rst) begin
      exp_ch <= N;
      model_ok <= 1'b1;
      visit_q.delete();
    end else if (model_ok) begin
      exp_ch <= (exp_ch % N) + 1;
      visit_q.push_back((exp_ch % N) + 1);
    end
  end

  always @(negedge clk) begin
    if (model_ok && !finished) begin
      logic [N-1:0]   e_sel;
      logic [2*N-1:0] e_sw;
      string t_idx;
      e_sel = '0; e_sel[exp_ch-1] = 1'b1;
      e_sw  = '0; e_sw[2*(exp_ch-1)] = 1'b1; e_sw[2*(exp_ch-1)+1] = 1'b1;
      // R1/R2 while parked by reset, R4 at the wrap points, R3 otherwise
      if (rst_seen)                       t_idx = "R2 parked index";
      else if (exp_ch == N || exp_ch == 1) t_idx = "R4 wrap index";
      else                                 t_idx = "R3 step index";
      check(ch_index == 7'(exp_ch), t_idx, 128'(ch_index), 128'(exp_ch));
      check(ch_index == 7'(exp_ch), "R9 index value", 128'(ch_index), 128'(exp_ch));
      check(ch_sel == e_sel, "R5 one-hot select", 128'(ch_sel), 128'(e_sel));
      check(sw_en_p == e_sw, "R6 leg enables", sw_en_p, e_sw);
      check(sw_en_n == ~e_sw, "R7 complement enables", sw_en_n, ~e_sw);
      check(serial_out == word_of(exp_ch, seed), "R8 serial word",
            128'(serial_out), 128'(word_of(exp_ch, seed)));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    samples_in = fill(0);
    step(1);
    // R1: first reset edge parks on channel 64
    #1.5;
    check(ch_index == 7'd64, "R1 reset parks", 128'(ch_index), 128'd64);
    check(ch_sel[63] == 1'b1, "R1 reset select", 128'(ch_sel), 128'(1) << 63);
    step(3);                      // R2: reset held over several edges
    rst = 1'b0;
    step(70);
    seed = 1; samples_in = fill(1);  // R8: samples change mid-scan
    step(60);
    // R3: ascending visit order 1.. since release
    for (int i = 0; i < 63; i++)
      check(visit_q[i] == i + 1, "R3 visit order", 128'(visit_q[i]), 128'(i + 1));
    check(visit_q[63] == 64, "R4 visit wrap", 128'(visit_q[63]), 128'd64);
    check(visit_q[64] == 1, "R4 visit restart", 128'(visit_q[64]), 128'd1);
    rst = 1'b1;                   // R2: reset in the middle of a scan
    step(3);
    rst = 1'b0;
    seed = 2; samples_in = fill(2);
    step(140);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule